// File: doc/BRIEF.md
# Token-to-Bank Command Splitter

This block sits between a token decoder and a banked history memory of an LZ77-style decompressor. Each token arrives as a literal, which carries its bytes, or a copy, which carries a length and a back-offset. The block turns the token into commands that each touch one bank of the history, so that every bank can work on its own share of the token. The history holds 64 KB, striped across 16 banks of 4 KB with 8-byte lines. The block keeps the running output write pointer inside the current 64 KB block.

A literal becomes up to three line-wide write commands. Each command has a line, a bank, eight data lanes and a byte mask. A copy becomes up to nine copy commands. Each copy command carries a source address whose bytes stay inside one source line, a destination address and a piece length. The executor that consumes copy commands handles destinations that straddle two banks. Literal commands and copy commands leave on separate paths. Each path has its own valid/ready pair, and the whole set of commands for one token is offered in the same cycle the token is presented.

Top module: `tok_bank_splitter`

## Requirements
- R1: A 16-bit history byte address A maps to lane A[2:0], bank A[6:3] and line A[15:7]. Every copy address port carries the full byte address in this layout.
- R2: For a literal of length L (1 to 16), with literal byte i taken from tok_lit[8i+7:8i], slot k covers the line that starts at the write pointer rounded down to 8, plus 8k. Mask bit j of slot k is set exactly when that line's lane j lies in [pointer, pointer+L). When set, data lane j (wr_data[k][8j+7:8j]) holds literal byte (lane address − pointer).
- R3: For a copy of length L (1 to 64) and offset D, the source start is (pointer − D) mod 65536. Slot 0 starts at the source start. Each following slot starts at the next source line boundary. No piece crosses a source line, the piece lengths are 1 to 8 and sum to L, and each piece's destination is pointer plus the same distance from the token start.
- R4: Command slots fill from slot 0 upward in address order, and every slot past the last piece is not valid.
- R5: The write pointer starts at 0 and advances by L in the cycle a non-error token is accepted. It is unchanged in any other cycle.
- R6: The write pointer and all addresses wrap modulo 65536, so a token that runs past the end of a 64 KB block continues at address 0.
- R7: A token is flagged with tok_err, accepted at once and produces no command, leaving the pointer unchanged, in any of these cases: length zero, a literal longer than 16, a copy longer than 64, a copy offset of zero, or a copy offset above 65536.
- R8: tok_ready follows wr_ready for a literal and cp_ready for a copy. wr_valid and cp_valid are raised only for a valid, non-error token of their own kind, and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token taken this cycle |
| tok_is_copy | input | 1 | 1 = copy token, 0 = literal |
| tok_len | input | 7 | Token length in bytes |
| tok_off | input | 17 | Copy back-offset (1 to 65536) |
| tok_lit | input | 128 | Literal bytes, byte i at bits 8i+7:8i |
| tok_err | output | 1 | Malformed token, dropped |
| wr_valid | output | 1 | Write-command set offered |
| wr_ready | input | 1 | Write path can take the set |
| wr_slot_vld | output | 3 | Per-slot write command present |
| wr_line | output | 3x9 | Line number per write slot |
| wr_bank | output | 3x4 | Bank number per write slot |
| wr_data | output | 3x64 | Lane data per write slot |
| wr_mask | output | 3x8 | Lane enables per write slot |
| cp_valid | output | 1 | Copy-command set offered |
| cp_ready | input | 1 | Copy path can take the set |
| cp_slot_vld | output | 9 | Per-slot copy command present |
| cp_rd_addr | output | 9x16 | Source byte address per slot |
| cp_wr_addr | output | 9x16 | Destination byte address per slot |
| cp_len | output | 9x4 | Piece length per slot (1 to 8) |

## Verification
Two functions meet in one cycle: the command set that a token produces is computed from the current pointer, and in that same cycle the token's acceptance moves the pointer. Random readiness on both command paths holds tokens for several cycles, and the pointer must not move until the token is accepted. A long run of 16-byte literals then forces a token across the 64 KB wrap while it is being split. A behavioural byte-by-byte model in the bench predicts every slot, mask, lane and address, and its results are compared with the design's on every clock.

// File: rtl/tbs_pkg.sv
// Shared geometry of the banked history buffer.
// Assumes a power-of-two line size, bank count and lines per bank.
package tbs_pkg;
    localparam int LINE_B = 8;                       // bytes per bank line
    localparam int NBANKS = 16;                      // banks in the history
    localparam int NLINES = 512;                     // lines per bank
    localparam int LANE_W = $clog2(LINE_B);
    localparam int BANK_W = $clog2(NBANKS);
    localparam int LINE_W = $clog2(NLINES);
    localparam int ADDR_W = LANE_W + BANK_W + LINE_W; // history byte address
    localparam int HIST_B = 1 << ADDR_W;             // bytes per history block
endpackage

// File: rtl/tbs_lit_split.sv
// Literal splitter: cuts one literal into line-wide write commands.
// Assumes len <= MAX_LIT. Slot k targets the line that starts at the
// aligned write pointer plus k lines, and address arithmetic wraps.
module tbs_lit_split #(
    parameter int MAX_LIT = 16,
    parameter int LEN_W   = 7,
    localparam int SLOTS  = MAX_LIT / tbs_pkg::LINE_B + 1,
    localparam int IDX_W  = $clog2(MAX_LIT)
) (
    input  logic [tbs_pkg::ADDR_W-1:0]                  wp,
    input  logic [LEN_W-1:0]                            len,
    input  logic [MAX_LIT*8-1:0]                        lit,
    output logic [SLOTS-1:0]                            slot_vld,
    output logic [SLOTS-1:0][tbs_pkg::LINE_W-1:0]       line,
    output logic [SLOTS-1:0][tbs_pkg::BANK_W-1:0]       bank,
    output logic [SLOTS-1:0][tbs_pkg::LINE_B*8-1:0]     data,
    output logic [SLOTS-1:0][tbs_pkg::LINE_B-1:0]       mask
);
    import tbs_pkg::*;

    logic [7:0]        lit_b [MAX_LIT];
    logic [ADDR_W-1:0] wp_al;

    // Unpack the literal into a byte array and align the pointer to a line.
    always_comb begin
        for (int i = 0; i < MAX_LIT; i++) lit_b[i] = lit[8*i +: 8];
        wp_al = {wp[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [ADDR_W-1:0] base;
        assign base        = wp_al + ADDR_W'(LINE_B * k);
        assign line[k]     = base[ADDR_W-1 -: LINE_W];
        assign bank[k]     = base[LANE_W +: BANK_W];
        assign slot_vld[k] = |mask[k];

        // Select, lane by lane, the literal byte that lands in this line.
        always_comb begin
            logic [ADDR_W-1:0] rel;
            mask[k] = '0;
            data[k] = '0;
            for (int j = 0; j < LINE_B; j++) begin
                rel = base + ADDR_W'(j) - wp;
                if (rel < ADDR_W'(len)) begin
                    mask[k][j]       = 1'b1;
                    data[k][8*j +: 8] = lit_b[rel[IDX_W-1:0]];
                end
            end
        end
    end
endmodule

// File: rtl/tbs_copy_split.sv
// Copy splitter: cuts one copy into pieces whose source bytes stay within
// one bank line. Assumes 1 <= len <= MAX_COPY. The offset arrives reduced
// modulo the history size, so an offset of a full block reads at wp.
module tbs_copy_split #(
    parameter int MAX_COPY = 64,
    parameter int LEN_W    = 7,
    localparam int SLOTS   = MAX_COPY / tbs_pkg::LINE_B + 1,
    localparam int REL_W   = LEN_W + 2,
    localparam int PL_W    = tbs_pkg::LANE_W + 1
) (
    input  logic [tbs_pkg::ADDR_W-1:0]              wp,
    input  logic [tbs_pkg::ADDR_W-1:0]              off,
    input  logic [LEN_W-1:0]                        len,
    output logic [SLOTS-1:0]                        slot_vld,
    output logic [SLOTS-1:0][tbs_pkg::ADDR_W-1:0]   rd_addr,
    output logic [SLOTS-1:0][tbs_pkg::ADDR_W-1:0]   wr_addr,
    output logic [SLOTS-1:0][PL_W-1:0]              plen
);
    import tbs_pkg::*;

    logic [ADDR_W-1:0] src;
    logic [PL_W-1:0]   first;

    // Source start and the bytes left before its line boundary.
    always_comb begin
        src   = wp - off;
        first = PL_W'(LINE_B) - PL_W'(src[LANE_W-1:0]);
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_piece
        logic [REL_W-1:0] start;
        logic [REL_W-1:0] left;
        logic [PL_W-1:0]  cap;

        if (k == 0) begin : g_head
            assign start = '0;
            assign cap   = first;
        end else begin : g_body
            assign start = REL_W'(first) + REL_W'(LINE_B * (k - 1));
            assign cap   = PL_W'(LINE_B);
        end

        // Piece k: its offset into the token, validity, length and addresses.
        always_comb begin
            left        = REL_W'(len) - start;
            slot_vld[k] = start < REL_W'(len);
            plen[k]     = (left < REL_W'(cap)) ? left[PL_W-1:0] : cap;
            rd_addr[k]  = src + ADDR_W'(start);
            wr_addr[k]  = wp + ADDR_W'(start);
        end
    end
endmodule

// File: rtl/tok_bank_splitter.sv
// Token-to-bank command splitter top. Screens each token, routes it to
// the literal or copy splitter, gates the command slots with the path
// handshake and advances the write pointer when a good token is taken.
// Assumes downstream takes a whole command set in one handshake.
module tok_bank_splitter #(
    parameter int MAX_LIT  = 16,
    parameter int MAX_COPY = 64,
    localparam int WR_SLOTS = MAX_LIT / tbs_pkg::LINE_B + 1,
    localparam int CP_SLOTS = MAX_COPY / tbs_pkg::LINE_B + 1,
    localparam int LEN_W    = $clog2(MAX_COPY + 1),
    localparam int OFF_W    = tbs_pkg::ADDR_W + 1,
    localparam int PL_W     = tbs_pkg::LANE_W + 1
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        tok_valid,
    output logic                                        tok_ready,
    input  logic                                        tok_is_copy,
    input  logic [LEN_W-1:0]                            tok_len,
    input  logic [OFF_W-1:0]                            tok_off,
    input  logic [MAX_LIT*8-1:0]                        tok_lit,
    output logic                                        tok_err,
    output logic                                        wr_valid,
    input  logic                                        wr_ready,
    output logic [WR_SLOTS-1:0]                         wr_slot_vld,
    output logic [WR_SLOTS-1:0][tbs_pkg::LINE_W-1:0]    wr_line,
    output logic [WR_SLOTS-1:0][tbs_pkg::BANK_W-1:0]    wr_bank,
    output logic [WR_SLOTS-1:0][tbs_pkg::LINE_B*8-1:0]  wr_data,
    output logic [WR_SLOTS-1:0][tbs_pkg::LINE_B-1:0]    wr_mask,
    output logic                                        cp_valid,
    input  logic                                        cp_ready,
    output logic [CP_SLOTS-1:0]                         cp_slot_vld,
    output logic [CP_SLOTS-1:0][tbs_pkg::ADDR_W-1:0]    cp_rd_addr,
    output logic [CP_SLOTS-1:0][tbs_pkg::ADDR_W-1:0]    cp_wr_addr,
    output logic [CP_SLOTS-1:0][PL_W-1:0]               cp_len
);
    import tbs_pkg::*;

    logic [ADDR_W-1:0]   wp_q;
    logic                bad;
    logic                take;
    logic [WR_SLOTS-1:0] lit_vld;
    logic [CP_SLOTS-1:0] cpy_vld;

    // Screen the token fields for malformed lengths and offsets.
    always_comb begin
        if (tok_len == '0) begin
            bad = 1'b1;
        end else if (!tok_is_copy) begin
            bad = tok_len > LEN_W'(MAX_LIT);
        end else begin
            bad = (tok_len > LEN_W'(MAX_COPY)) || (tok_off == '0) ||
                  (tok_off > OFF_W'(HIST_B));
        end
    end

    // Handshake: errors are swallowed at once, good tokens wait for their path.
    always_comb begin
        tok_ready = bad || (tok_is_copy ? cp_ready : wr_ready);
        tok_err   = tok_valid && bad;
        wr_valid  = tok_valid && !bad && !tok_is_copy;
        cp_valid  = tok_valid && !bad && tok_is_copy;
        take      = tok_valid && tok_ready && !bad;
    end

    // Running write pointer inside the current history block.
    always_ff @(posedge clk) begin
        if (!rst_n)    wp_q <= '0;
        else if (take) wp_q <= wp_q + ADDR_W'(tok_len);
    end

    tbs_lit_split #(.MAX_LIT(MAX_LIT), .LEN_W(LEN_W)) u_lit (
        .wp(wp_q), .len(tok_len), .lit(tok_lit),
        .slot_vld(lit_vld), .line(wr_line), .bank(wr_bank),
        .data(wr_data), .mask(wr_mask)
    );

    tbs_copy_split #(.MAX_COPY(MAX_COPY), .LEN_W(LEN_W)) u_cpy (
        .wp(wp_q), .off(tok_off[ADDR_W-1:0]), .len(tok_len),
        .slot_vld(cpy_vld), .rd_addr(cp_rd_addr), .wr_addr(cp_wr_addr),
        .plen(cp_len)
    );

    // Slots are only offered while their path is offered.
    always_comb begin
        wr_slot_vld = wr_valid ? lit_vld : '0;
        cp_slot_vld = cp_valid ? cpy_vld : '0;
    end
endmodule

// File: rtl/tbs_chk.sv
// Checker for tok_bank_splitter: path exclusion, error silence, byte
// conservation on both paths, copy pieces inside one source line, and
// pointer stepping.
module tbs_chk #(
    parameter int WR_SLOTS = 3,
    parameter int CP_SLOTS = 9,
    parameter int LEN_W    = 7,
    parameter int LINE_B   = 8,
    parameter int ADDR_W   = 16,
    parameter int PL_W     = 4
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                tok_valid,
    input logic                                tok_ready,
    input logic                                tok_err,
    input logic [LEN_W-1:0]                    tok_len,
    input logic                                wr_valid,
    input logic                                cp_valid,
    input logic [WR_SLOTS-1:0][LINE_B-1:0]     wr_mask,
    input logic [CP_SLOTS-1:0]                 cp_slot_vld,
    input logic [CP_SLOTS-1:0][ADDR_W-1:0]     cp_rd_addr,
    input logic [CP_SLOTS-1:0][PL_W-1:0]       cp_len,
    input logic [ADDR_W-1:0]                   wp
);
    int lit_sum;
    int cp_sum;

    // Bytes carried by the offered slots of each path.
    always_comb begin
        lit_sum = 0;
        cp_sum  = 0;
        for (int k = 0; k < WR_SLOTS; k++) lit_sum += $countones(wr_mask[k]);
        for (int k = 0; k < CP_SLOTS; k++)
            if (cp_slot_vld[k]) cp_sum += int'(cp_len[k]);
    end

    assert_paths_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && cp_valid));

    assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tok_err |-> (tok_ready && !wr_valid && !cp_valid));

    assert_lit_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (lit_sum == int'(tok_len)));

    assert_copy_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid |-> (cp_sum == int'(tok_len)));

    for (genvar k = 0; k < CP_SLOTS; k++) begin : g_piece_chk
        assert_piece_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cp_slot_vld[k] |-> (cp_len[k] != '0) &&
                (int'(cp_rd_addr[k] % ADDR_W'(LINE_B)) + int'(cp_len[k]) <= LINE_B));
    end

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && !tok_err) |=> (wp == $past(wp + ADDR_W'(tok_len))));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tok_valid && tok_ready && !tok_err) |=> $stable(wp));
endmodule

bind tok_bank_splitter tbs_chk #(
    .WR_SLOTS(WR_SLOTS), .CP_SLOTS(CP_SLOTS), .LEN_W(LEN_W),
    .LINE_B(tbs_pkg::LINE_B), .ADDR_W(tbs_pkg::ADDR_W), .PL_W(PL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_err(tok_err), .tok_len(tok_len), .wr_valid(wr_valid),
    .cp_valid(cp_valid), .wr_mask(wr_mask), .cp_slot_vld(cp_slot_vld),
    .cp_rd_addr(cp_rd_addr), .cp_len(cp_len), .wp(wp_q)
);

// File: tb/tok_bank_splitter_bench.sv
// Bench: byte-level reference model of the splitter, compared every cycle.
module tok_bank_splitter_bench;
    localparam int WS = 3;
    localparam int CS = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_valid = 1'b0, tok_is_copy = 1'b0, wr_ready = 1'b0, cp_ready = 1'b0;
    logic [6:0]   tok_len = '0;
    logic [16:0]  tok_off = '0;
    logic [127:0] tok_lit = '0;
    logic tok_ready, tok_err, wr_valid, cp_valid;
    logic [WS-1:0] wr_slot_vld;
    logic [WS-1:0][8:0]  wr_line;
    logic [WS-1:0][3:0]  wr_bank;
    logic [WS-1:0][63:0] wr_data;
    logic [WS-1:0][7:0]  wr_mask;
    logic [CS-1:0] cp_slot_vld;
    logic [CS-1:0][15:0] cp_rd_addr, cp_wr_addr;
    logic [CS-1:0][3:0]  cp_len;

    int checks = 0;
    int errors = 0;
    int mwp = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tok_bank_splitter u_tok_bank_splitter (.*);

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model the current cycle, compare, then update the model pointer.
    task automatic model_cycle();
        bit bad, ev_w, ev_c, rdy, wrap;
        bit [WS-1:0] e_wv;
        bit [CS-1:0] e_cv;
        int e_line[WS], e_bank[WS], e_mask[WS], e_rd[CS], e_wr[CS], e_ln[CS];
        longint e_data[WS];
        int L, p, a, s, src0;
        L = int'(tok_len);
        bad = (L == 0) || (!tok_is_copy && L > 16) ||
              (tok_is_copy && (L > 64 || tok_off == 0 || tok_off > 65536));
        rdy  = bad || (tok_is_copy ? cp_ready : wr_ready);
        ev_w = tok_valid && !bad && !tok_is_copy;
        ev_c = tok_valid && !bad && tok_is_copy;
        wrap = (mwp + L) > 65535;
        e_wv = '0; e_cv = '0;
        for (int k = 0; k < WS; k++) begin e_mask[k] = 0; e_data[k] = 0; e_line[k] = 0; e_bank[k] = 0; end
        for (int k = 0; k < CS; k++) begin e_rd[k] = 0; e_wr[k] = 0; e_ln[k] = 0; end
        if (ev_w) begin
            for (int i = 0; i < L; i++) begin
                a = (mwp + i) & 16'hFFFF;
                s = ((a - (mwp & 16'hFFF8)) & 16'hFFFF) >> 3;
                e_wv[s] = 1'b1;
                e_mask[s] |= 1 << (a % 8);
                e_data[s] |= longint'(tok_lit[8*i +: 8]) << (8 * (a % 8));
                e_line[s] = a >> 7;
                e_bank[s] = (a >> 3) & 15;
            end
        end
        if (ev_c) begin
            src0 = (mwp - int'(tok_off)) & 16'hFFFF;
            p = -1;
            for (int i = 0; i < L; i++) begin
                s = (src0 + i) & 16'hFFFF;
                if (i == 0 || s % 8 == 0) begin
                    p++;
                    e_cv[p] = 1'b1;
                    e_rd[p] = s;
                    e_wr[p] = (mwp + i) & 16'hFFFF;
                end
                e_ln[p]++;
            end
        end
        chk("R8", "tok_ready", tok_ready, rdy);
        chk("R7", "tok_err", tok_err, tok_valid && bad);
        chk("R8", "wr_valid", wr_valid, ev_w);
        chk("R8", "cp_valid", cp_valid, ev_c);
        chk("R4", "wr_slot_vld", wr_slot_vld, e_wv);
        chk("R4", "cp_slot_vld", cp_slot_vld, e_cv);
        for (int k = 0; k < WS; k++) if (e_wv[k]) begin
            chk(wrap ? "R6" : "R1", "wr_line", wr_line[k], e_line[k]);
            chk(wrap ? "R6" : "R5", "wr_bank", wr_bank[k], e_bank[k]);
            chk("R2", "wr_mask", wr_mask[k], e_mask[k]);
            chk("R2", "wr_data", wr_data[k], e_data[k]);
        end
        for (int k = 0; k < CS; k++) if (e_cv[k]) begin
            chk("R3", "cp_rd_addr", cp_rd_addr[k], e_rd[k]);
            chk(wrap ? "R6" : "R5", "cp_wr_addr", cp_wr_addr[k], e_wr[k]);
            chk("R3", "cp_len", cp_len[k], e_ln[k]);
        end
        if (tok_valid && rdy && !bad) mwp = (mwp + L) & 16'hFFFF;
    endtask

    task automatic step();
        @(negedge clk);
        model_cycle();
    endtask

    task automatic drive_rand();
        int r;
        r = $urandom_range(0, 99);
        tok_valid   = $urandom_range(0, 9) != 0;
        tok_is_copy = $urandom_range(0, 1);
        wr_ready    = $urandom_range(0, 3) != 0;
        cp_ready    = $urandom_range(0, 3) != 0;
        tok_lit     = {$urandom, $urandom, $urandom, $urandom};
        tok_len     = tok_is_copy ? 7'($urandom_range(1, 64)) : 7'($urandom_range(1, 16));
        tok_off     = 17'($urandom_range(1, 40));
        if (r < 10)      tok_off = 17'($urandom_range(1, 65536));
        else if (r < 12) tok_off = 17'd65536;
        else if (r < 14) tok_len = '0;                             // R7 zero length
        else if (r < 16) tok_off = '0;                             // R7 zero offset
        else if (r < 18) tok_len = tok_is_copy ? 7'd65 : 7'd17;   // R7 too long
        else if (r < 19) tok_off = 17'd65537;                      // R7 offset too far
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        step();                     // R5: idle outputs while held in reset
        @(posedge clk); #1 rst_n = 1'b1;
        step();
        // R5: first literal after reset lands at address 0 (line 0, bank 0)
        @(posedge clk); #1;
        tok_valid = 1; tok_is_copy = 0; tok_len = 7'd5; wr_ready = 1; cp_ready = 1;
        tok_lit = 128'h0f0e0d0c0b0a09080706050403020100;
        step();
        // R3: copy across lines with a short offset (overlapping source)
        @(posedge clk); #1;
        tok_is_copy = 1; tok_len = 7'd20; tok_off = 17'd3;
        step();
        // R8: stalled copy must hold the pointer
        @(posedge clk); #1 cp_ready = 0;
        step();
        @(posedge clk); #1 cp_ready = 1;
        step();
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #1 drive_rand();
            step();
        end
        // R6: stream 16-byte literals until the pointer passes the block end
        for (int n = 0; n < 4100; n++) begin
            @(posedge clk); #1;
            tok_valid = 1; tok_is_copy = 0; tok_len = 7'd16; wr_ready = 1;
            tok_lit = {$urandom, $urandom, $urandom, $urandom};
            if (n % 512 == 7) begin tok_len = 7'd13; end
            step();
        end
        // R6: full-block offset copy right after the wrap
        @(posedge clk); #1 tok_is_copy = 1; tok_len = 7'd64; tok_off = 17'd65536; cp_ready = 1;
        step();
        @(posedge clk); #1 tok_valid = 0;
        step();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule